// File: doc/BRIEF.md
# Pairwise Win-Count Ranking Unit

This unit ranks five contestants from their 4-bit vote tallies without sorting them. Every contestant is weighed against each of the other four with a strict magnitude comparison. The comparisons a contestant wins are summed into a small win count, and two exact values of that count are decoded into place indicators: a count of three marks second place, and a count of two marks third place.

Results are registered. The win counts and both flag vectors are updated together on the rising clock edge that follows a change of the tallies, so they are due one cycle later. Ties are passed through without any special handling. Equal tallies give neither side a win, so several contestants may share a place flag, or no contestant may hold it. An asynchronous active-low reset clears every output.

Top module: `rank_unit`

## Requirements
- R1: A comparison between two contestants scores a win only for the one whose tally is strictly larger; equal tallies score nothing for either side.
- R2: The win count of each contestant equals the number of the other four whose tally is strictly smaller, so it lies between 0 and 4 inclusive.
- R3: The third-place flag of a contestant is high exactly when its win count is 2 (binary 010).
- R4: The second-place flag of a contestant is high exactly when its win count is 3 (binary 011); a contestant never shows both flags.
- R5: All outputs take their new values together on the first rising clock edge after the tallies change, and hold their old values before that edge.
- R6: While rst_n is low, every win count reads 0 and every flag is low, whatever the tallies are.
- R7: Tied tallies may leave several contestants with the same place flag, or none with it. Such results are shown as they are and are not suppressed.
- R8: For any pair at most one contestant scores the win, so the win counts of all five add up to no more than 10.
- R9: When all five tallies are equal, including all zero, every win count is 0 and every flag is low.
- R10: Contestant k takes tally_i bits [4k+3:4k], wins_o bits [3k+2:3k], and bit k of second_o and third_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tally_i | input | 20 | Five 4-bit vote tallies, contestant k in bits [4k+3:4k] |
| wins_o | output | 15 | Five 3-bit win counts, contestant k in bits [3k+2:3k] |
| second_o | output | 5 | Second-place flag per contestant (win count of 3) |
| third_o | output | 5 | Third-place flag per contestant (win count of 2) |

## Verification
The win counts and both flag vectors lag the tallies by exactly one rising edge. The bench therefore drives each tally set on a falling edge and reads every result on the next falling edge, after that single register stage has loaded. One directed case reads the outputs one nanosecond after a new drive, which is before the capturing edge, to confirm that they still show the previous results. Reset is asynchronous, so its clearing effect is read within the same half cycle in which rst_n falls.

// File: rtl/rank_pkg.sv
package rank_pkg;

  // Win-count values that mark a place
  localparam int unsigned SECOND_PLACE_WINS = 3;
  localparam int unsigned THIRD_PLACE_WINS  = 2;

  // Bits needed to hold values 0..max_val
  function automatic int unsigned bits_for(input int unsigned max_val);
    int unsigned b;
    b = 1;
    while ((32'd1 << b) <= max_val) b = b + 1;
    return b;
  endfunction

endpackage

// File: rtl/rank_pair_matrix.sv
// Full matrix of strict pairwise comparisons. beat_o[i*N+j] means
// contestant i holds more votes than contestant j. Each ordered pair
// has its own comparator, so both halves of the matrix are computed
// independently.
module rank_pair_matrix #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 4
) (
  input  logic [N*CW-1:0] tally_i,
  output logic [N*N-1:0]  beat_o
);

  function automatic logic strictly_above(input logic [CW-1:0] mine,
                                          input logic [CW-1:0] theirs);
    return mine > theirs;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_self
        assign beat_o[i*N+j] = 1'b0;
      end else begin : g_cmp
        assign beat_o[i*N+j] = strictly_above(tally_i[i*CW +: CW],
                                              tally_i[j*CW +: CW]);
      end
    end
  end

endmodule

// File: rtl/rank_win_adder.sv
// Two-stage sum of comparison wins. Stage one adds the hits in pairs
// into 2-bit partial sums. Stage two adds the partial sums into the
// full win count.
module rank_win_adder #(
  parameter int unsigned NI = 4,
  parameter int unsigned WW = 3
) (
  input  logic [NI-1:0] hits_i,
  output logic [WW-1:0] sum_o
);

  localparam int unsigned NP = (NI + 1) / 2;

  logic [2*NP-1:0]     padded;
  logic [NP-1:0][1:0]  pair_sum;

  always_comb begin
    padded         = '0;
    padded[NI-1:0] = hits_i;
  end

  function automatic logic [1:0] half_add(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  for (genvar p = 0; p < NP; p++) begin : g_stage1
    assign pair_sum[p] = half_add(padded[2*p], padded[2*p+1]);
  end

  always_comb begin
    logic [WW-1:0] acc;
    acc = '0;
    for (int p = 0; p < NP; p++) acc = acc + WW'(pair_sum[p]);
    sum_o = acc;
  end

endmodule

// File: rtl/rank_place_decode.sv
// Exact-value decode of a win count into place flags.
module rank_place_decode #(
  parameter int unsigned WW = 3
) (
  input  logic [WW-1:0] wins_i,
  output logic          second_o,
  output logic          third_o
);
  import rank_pkg::*;

  function automatic logic is_exact(input logic [WW-1:0] w,
                                    input int unsigned   target);
    return w == WW'(target);
  endfunction

  assign second_o = is_exact(wins_i, SECOND_PLACE_WINS);
  assign third_o  = is_exact(wins_i, THIRD_PLACE_WINS);

endmodule

// File: rtl/rank_unit.sv
module rank_unit #(
  parameter  int unsigned N  = 5,
  parameter  int unsigned CW = 4,
  localparam int unsigned WW = rank_pkg::bits_for(N - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*CW-1:0] tally_i,
  output logic [N*WW-1:0] wins_o,
  output logic [N-1:0]    second_o,
  output logic [N-1:0]    third_o
);
  import rank_pkg::*;

  localparam int unsigned PAIRS = N * (N - 1) / 2;
  localparam int unsigned TW    = bits_for(PAIRS);

  // Comparison matrix, brought out as a named net for the checks
  logic [N*N-1:0] beat;

  rank_pair_matrix #(.N(N), .CW(CW)) u_pairs (
    .tally_i (tally_i),
    .beat_o  (beat)
  );

  logic [N-1:0][WW-1:0] wins_d, wins_q;
  logic [N-1:0]         second_d, third_d, second_q, third_q;

  for (genvar i = 0; i < N; i++) begin : g_contestant
    logic [N-2:0] hits;

    for (genvar k = 0; k < N - 1; k++) begin : g_opp
      localparam int unsigned OPP = (k < i) ? k : k + 1;
      assign hits[k] = beat[i*N+OPP];
    end

    rank_win_adder #(.NI(N-1), .WW(WW)) u_add (
      .hits_i (hits),
      .sum_o  (wins_d[i])
    );

    rank_place_decode #(.WW(WW)) u_dec (
      .wins_i   (wins_d[i]),
      .second_o (second_d[i]),
      .third_o  (third_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wins_q   <= '0;
      second_q <= '0;
      third_q  <= '0;
    end else begin
      wins_q   <= wins_d;
      second_q <= second_d;
      third_q  <= third_d;
    end
  end

  assign wins_o   = wins_q;
  assign second_o = second_q;
  assign third_o  = third_q;

  // Total of all registered win counts, for the pair-balance check
  logic [TW-1:0] total_wins;
  always_comb begin
    logic [TW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + TW'(wins_q[i]);
    total_wins = acc;
  end

  AST_TOTAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    total_wins <= TW'(PAIRS)); // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wins_q[i] <= WW'(N - 1)); // R2
    AST_THIRD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      third_q[i] == (wins_q[i] == WW'(THIRD_PLACE_WINS))); // R3
    AST_SECOND_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      second_q[i] == (wins_q[i] == WW'(SECOND_PLACE_WINS))); // R4
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(second_q[i] && third_q[i])); // R4
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      AST_ANTISYM: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat[i*N+j] && beat[j*N+i])); // R8
    end
  end

endmodule

// File: tb/rank_unit_test.sv
`timescale 1ns/1ps
module rank_unit_test;

  localparam int N  = 5;
  localparam int CW = 4;
  localparam int WW = 3;
  localparam int NV = 12;
  localparam int WD_CYCLES = 20000;

  // Stimulus tallies (contestant 0..4) and hand-worked win counts
  localparam int VEC_CNT [NV][5] = '{
    '{1, 2, 3, 4, 5},   '{5, 4, 3, 2, 1},   '{3, 3, 3, 3, 3},
    '{7, 2, 2, 0, 9},   '{4, 4, 1, 1, 0},   '{15, 0, 15, 0, 8},
    '{2, 6, 6, 6, 1},   '{0, 0, 0, 0, 10},  '{9, 8, 0, 0, 0},
    '{15, 14, 13, 12, 11}, '{6, 1, 6, 1, 6}, '{0, 5, 0, 5, 3}
  };
  localparam int VEC_WIN [NV][5] = '{
    '{0, 1, 2, 3, 4},   '{4, 3, 2, 1, 0},   '{0, 0, 0, 0, 0},
    '{3, 1, 1, 0, 4},   '{3, 3, 1, 1, 0},   '{3, 0, 3, 0, 2},
    '{1, 2, 2, 2, 0},   '{0, 0, 0, 0, 4},   '{4, 3, 0, 0, 0},
    '{4, 3, 2, 1, 0},   '{2, 0, 2, 0, 2},   '{0, 3, 0, 3, 2}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*CW-1:0] tally_i = '0;
  logic [N*WW-1:0] wins_o;
  logic [N-1:0]    second_o, third_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rank_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tally_i  (tally_i),
    .wins_o   (wins_o),
    .second_o (second_o),
    .third_o  (third_o)
  );

  task automatic set_counts(input int c[5]);
    for (int k = 0; k < N; k++) tally_i[k*CW +: CW] = CW'(c[k]);
  endtask

  task automatic check_val(input string req, input string what, input int k,
                           input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s contestant %0d: actual %0d expected %0d",
               req, what, k, act, exp);
    end
  endtask

  // Checks win counts (tagged wreq) and both flags derived from expected wins
  task automatic check_all(input string wreq, input int e[5]);
    int total;
    total = 0;
    for (int k = 0; k < N; k++) begin
      check_val(wreq, "wins", k, int'(wins_o[k*WW +: WW]), e[k]);
      check_val("R4", "second", k, int'(second_o[k]), (e[k] == 3) ? 1 : 0);
      check_val("R3", "third", k, int'(third_o[k]), (e[k] == 2) ? 1 : 0);
      total += int'(wins_o[k*WW +: WW]);
    end
    checks++;
    if (total > 10) begin
      fails++;
      $display("FAIL R8 win total: actual %0d expected at most 10", total);
    end
  endtask

  task automatic apply(input int c[5]);
    @(negedge clk);
    set_counts(c);
    @(negedge clk);
  endtask

  initial begin
    // R6: reset state with nonzero tallies present
    set_counts('{1, 2, 3, 4, 5});
    repeat (3) @(negedge clk);
    check_all("R6", '{0, 0, 0, 0, 0});
    rst_n = 1'b1;

    // R2: table of vectors
    for (int v = 0; v < NV; v++) begin
      apply(VEC_CNT[v]);
      check_all("R2", VEC_WIN[v]);
    end

    // R1: equal tallies give no win to either side
    apply('{6, 6, 2, 2, 2});
    check_all("R1", '{3, 3, 0, 0, 0});

    // R7: shared third place, then no flags at all
    apply('{8, 8, 8, 1, 0});
    check_all("R7", '{2, 2, 2, 1, 0});
    apply('{5, 5, 5, 5, 1});
    check_all("R7", '{1, 1, 1, 1, 0});

    // R9: all equal
    apply('{0, 0, 0, 0, 0});
    check_all("R9", '{0, 0, 0, 0, 0});
    apply('{15, 15, 15, 15, 15});
    check_all("R9", '{0, 0, 0, 0, 0});

    // R8: fully ordered tallies use every pair
    apply('{1, 2, 3, 4, 5});
    check_all("R8", '{0, 1, 2, 3, 4});

    // R10: field positions of the highest contestants
    apply('{0, 0, 0, 2, 1});
    check_all("R10", '{0, 0, 0, 4, 3});

    // R5: old results hold until the capturing edge
    apply('{5, 4, 3, 2, 1});
    @(negedge clk);
    set_counts('{1, 2, 3, 4, 5});
    #1;
    check_all("R5", '{4, 3, 2, 1, 0});
    @(negedge clk);
    check_all("R5", '{0, 1, 2, 3, 4});

    // R6: asynchronous reset in mid operation
    rst_n = 1'b0;
    #1;
    check_all("R6", '{0, 0, 0, 0, 0});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R6", '{0, 1, 2, 3, 4});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule